// File: doc/BRIEF.md
# Interleaved Mipmap Bank Address Mapper

This block takes one trilinear mipmap lookup and produces the eight per-bank memory addresses that fetch it. The texture memory is split into two panels. Each panel is interleaved 2x2 across four memory chips, so there are eight banks in total. A request carries integer texel coordinates at the finer of the two bracketing levels, that level's number, a base row/column offset for the map, a map parity flag and a replicated-texture flag. The block reads the fine level and the next coarser level. For each of them it forms the 2x2 neighbour footprint, clamped to the level's edge, and sends every texel to the bank named by its level's panel, its row parity and its column parity. As a result, each bank receives exactly one row/column pair per lookup, and all banks can run a full row-and-column access in lockstep.

Each level is stored in one panel. Consecutive levels go to opposite panels, and the map parity sets which panel holds the even levels. Within a panel, every level of a map shares one row band. Level L starts at a column offset of N0 - (N0 >> L) bank columns, so the offsets come from shifts and a subtract. Replicated textures hold a second copy in the other internal SDRAM bank of the other panel. A ping-pong bit chooses the copy and flips on each accepted replicated lookup, so that a row activate on one internal bank overlaps the burst on the other. Requests enter on a valid/ready handshake. The addresses leave from a single register stage that holds its contents under backpressure.

Top module: `tex_bank_mapper`

## Requirements
- R1: After reset, out_valid_o is 0 and req_ready_o is 1.
- R2: Bank index b = 4*panel + 2*row_parity + col_parity. Slice b of each output bus belongs to bank b. The fine level is F and the coarse level is F+1. The panel of level L is L[0] xor req_odd_i. Every lookup therefore fills all eight banks.
- R3: At level L the size is n = 2^(MAP_LG-L). The coordinates are u,v for the fine level and u>>1,v>>1 for the coarse level. Each coordinate is first clamped to n-1, giving p. The odd-parity half index is p>>1. The even-parity half index is min((p+1)>>1, (n-1)>>1). Row = base_row + row half index. Column = base_col + N0 - (N0>>L) + column half index, where N0 = 2^MAP_LG. Both wrap modulo their field width.
- R4: A requested level above MAP_LG-1 is treated as MAP_LG-1.
- R5: For a replicated request, the internal-bank select of bank b is pp xor b[2], where pp is the ping-pong state at acceptance. For a non-replicated request it is 0.
- R6: pp toggles on each accepted replicated request. Non-replicated requests and requests that are not accepted leave pp unchanged.
- R7: clr_i forces pp to 0 at the next edge and takes priority over a toggle. A request accepted in the same cycle uses the old pp.
- R8: A request accepted at a clock edge appears at the outputs, with out_valid_o high, directly after that edge.
- R9: While out_valid_o is high and out_ready_i is low, all outputs hold their values.
- R10: req_ready_o is high exactly when out_valid_o is low or out_ready_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the ping-pong state |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_lvl_i | input | LVL_W | Fine mip level |
| req_u_i | input | MAP_LG | Column texel coordinate at the fine level |
| req_v_i | input | MAP_LG | Row texel coordinate at the fine level |
| req_base_row_i | input | ROW_W | Map base row, in bank rows |
| req_base_col_i | input | COL_W | Map base column, in bank columns |
| req_odd_i | input | 1 | Map parity: 1 puts the even levels in panel 1 |
| req_repl_i | input | 1 | Texture is replicated across internal banks |
| out_valid_o | output | 1 | Address set valid |
| out_ready_i | input | 1 | Downstream accepts the address set |
| out_row_o | output | 8*ROW_W | Row address per bank, bank b at slice b |
| out_col_o | output | 8*COL_W | Column address per bank, bank b at slice b |
| out_ibank_o | output | 8 | Internal SDRAM bank select per bank |

## Verification
Interior coordinates at level 0 and at a middle level show whether each texel goes to the bank of its row and column parity, and whether the two levels go to the right panels for both map parities. Coordinates on and beyond the level edge, level MAP_LG-1 (whose coarse level is one texel) and out-of-range levels separate correct clamping of the even half index and of the level from wrap-around. Sequences that mix replicated and non-replicated requests, stalls and clears show whether the ping-pong select advances only on accepted replicated lookups. A long random run with random backpressure compares every output against the bench model on every clock.

// File: rtl/tex_bank_pkg.sv
package tex_bank_pkg;
  localparam int unsigned NUM_BANKS = 8;
  localparam int unsigned NUM_TAPS  = 2;  // fine and coarse level

  function automatic logic [2:0] bank_of(input logic panel, input logic row_par,
                                         input logic col_par);
    return {panel, row_par, col_par};
  endfunction
endpackage

// File: rtl/mip_lvl_tap.sv
// Footprint addresses for one level: half indices per parity, plus level offset.
module mip_lvl_tap #(
  parameter int MAP_LG = 8,
  parameter int LVL_W  = 4,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10
) (
  input  logic [LVL_W-1:0]           lvl_i,
  input  logic [MAP_LG-1:0]          u_i,
  input  logic [MAP_LG-1:0]          v_i,
  input  logic [ROW_W-1:0]           base_row_i,
  input  logic [COL_W-1:0]           base_col_i,
  output logic [1:0][ROW_W-1:0]      row_o,
  output logic [1:0][COL_W-1:0]      col_o
);
  localparam int CW = MAP_LG + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << MAP_LG;

  logic [CW-1:0] size_w, last_w, lim_w, pu, pv, u_ext, v_ext;
  logic [CW-1:0] hu_lo, hv_lo, col_off;

  always_comb begin
    size_w  = FULL >> lvl_i;
    last_w  = size_w - CW'(1);
    lim_w   = last_w >> 1;
    u_ext   = {1'b0, u_i};
    v_ext   = {1'b0, v_i};
    pu      = (u_ext > last_w) ? last_w : u_ext;
    pv      = (v_ext > last_w) ? last_w : v_ext;
    // even member of the pair is p or p+1; keep it inside the level
    hu_lo   = ((pu + CW'(1)) >> 1) > lim_w ? lim_w : ((pu + CW'(1)) >> 1);
    hv_lo   = ((pv + CW'(1)) >> 1) > lim_w ? lim_w : ((pv + CW'(1)) >> 1);
    col_off = FULL - size_w;
    row_o[0] = base_row_i + ROW_W'(hv_lo);
    row_o[1] = base_row_i + ROW_W'(pv >> 1);
    col_o[0] = base_col_i + COL_W'(col_off + hu_lo);
    col_o[1] = base_col_i + COL_W'(col_off + (pu >> 1));
  end
endmodule

// File: rtl/pp_toggle.sv
module pp_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic sel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_o <= 1'b0;
    else if (clr_i)  sel_o <= 1'b0;
    else if (step_i) sel_o <= ~sel_o;
  end
endmodule

// File: rtl/tex_bank_mapper.sv
module tex_bank_mapper
  import tex_bank_pkg::*;
#(
  parameter int MAP_LG = 8,
  parameter int LVL_W  = 4,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [LVL_W-1:0]            req_lvl_i,
  input  logic [MAP_LG-1:0]           req_u_i,
  input  logic [MAP_LG-1:0]           req_v_i,
  input  logic [ROW_W-1:0]            req_base_row_i,
  input  logic [COL_W-1:0]            req_base_col_i,
  input  logic                        req_odd_i,
  input  logic                        req_repl_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [NUM_BANKS*ROW_W-1:0]  out_row_o,
  output logic [NUM_BANKS*COL_W-1:0]  out_col_o,
  output logic [NUM_BANKS-1:0]        out_ibank_o
);
  localparam int LVL_MAX = MAP_LG - 1;

  logic                                 accept;
  logic                                 pp_q;
  logic [LVL_W-1:0]                     lvl_fine;
  logic [NUM_TAPS-1:0][LVL_W-1:0]       lvl_tap;
  logic [NUM_TAPS-1:0]                  panel;
  logic [NUM_TAPS-1:0][1:0][ROW_W-1:0]  tap_row;
  logic [NUM_TAPS-1:0][1:0][COL_W-1:0]  tap_col;
  logic [NUM_BANKS-1:0][ROW_W-1:0]      row_nxt, row_q;
  logic [NUM_BANKS-1:0][COL_W-1:0]      col_nxt, col_q;
  logic [NUM_BANKS-1:0]                 ib_nxt, ib_q;
  logic                                 valid_q;

  assign req_ready_o = ~valid_q | out_ready_i;
  assign accept      = req_valid_i & req_ready_o;
  assign lvl_fine    = (req_lvl_i > LVL_W'(LVL_MAX)) ? LVL_W'(LVL_MAX) : req_lvl_i;

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign lvl_tap[k] = lvl_fine + LVL_W'(k);
    assign panel[k]   = lvl_tap[k][0] ^ req_odd_i;

    mip_lvl_tap #(
      .MAP_LG(MAP_LG), .LVL_W(LVL_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_tap (
      .lvl_i      (lvl_tap[k]),
      .u_i        (req_u_i >> k),
      .v_i        (req_v_i >> k),
      .base_row_i (req_base_row_i),
      .base_col_i (req_base_col_i),
      .row_o      (tap_row[k]),
      .col_o      (tap_col[k])
    );
  end

  // scatter the 2x2 footprint of each level onto its panel's four banks
  always_comb begin
    row_nxt = '0;
    col_nxt = '0;
    ib_nxt  = '0;
    for (int k = 0; k < NUM_TAPS; k++) begin
      for (int rp = 0; rp < 2; rp++) begin
        for (int cp = 0; cp < 2; cp++) begin
          row_nxt[bank_of(panel[k], 1'(rp), 1'(cp))] = tap_row[k][rp];
          col_nxt[bank_of(panel[k], 1'(rp), 1'(cp))] = tap_col[k][cp];
          ib_nxt[bank_of(panel[k], 1'(rp), 1'(cp))]  = req_repl_i & (pp_q ^ panel[k]);
        end
      end
    end
  end

  pp_toggle u_pp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .step_i (accept & req_repl_i),
    .sel_o  (pp_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      ib_q    <= '0;
    end else if (accept) begin
      valid_q <= 1'b1;
      row_q   <= row_nxt;
      col_q   <= col_nxt;
      ib_q    <= ib_nxt;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_row_o   = row_q;
  assign out_col_o   = col_q;
  assign out_ibank_o = ib_q;
endmodule

// File: rtl/tex_bank_mapper_chk.sv
module tex_bank_mapper_chk #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clr_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_repl_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [8*ROW_W-1:0] out_row_o,
  input logic [8*COL_W-1:0] out_col_o,
  input logic [7:0]         out_ibank_o,
  input logic               pp_q
);
  // R8
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> out_valid_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_row_o)
                                       && $stable(out_col_o) && $stable(out_ibank_o)));

  // R10
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !req_ready_o);

  // R5
  ibank_panels_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((out_ibank_o == 8'h00) ||
                     (out_ibank_o == 8'h0f) || (out_ibank_o == 8'hf0)));

  // R6
  pp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && req_valid_i && req_ready_o && req_repl_i) |=> (pp_q != $past(pp_q)));

  // R6
  pp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(req_valid_i && req_ready_o && req_repl_i)) |=> $stable(pp_q));

  // R7
  pp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pp_q);
endmodule

bind tex_bank_mapper tex_bank_mapper_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_repl_i  (req_repl_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_row_o   (out_row_o),
  .out_col_o   (out_col_o),
  .out_ibank_o (out_ibank_o),
  .pp_q        (pp_q)
);

// File: tb/tex_bank_mapper_tb.sv
module tex_bank_mapper_tb;
  localparam int MAP_LG = 8;
  localparam int LVL_W  = 4;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 10;
  localparam int NB     = 8;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                clr_i = 1'b0;
  logic                req_valid_i = 1'b0;
  logic                req_ready_o;
  logic [LVL_W-1:0]    req_lvl_i = '0;
  logic [MAP_LG-1:0]   req_u_i = '0;
  logic [MAP_LG-1:0]   req_v_i = '0;
  logic [ROW_W-1:0]    req_base_row_i = '0;
  logic [COL_W-1:0]    req_base_col_i = '0;
  logic                req_odd_i = 1'b0;
  logic                req_repl_i = 1'b0;
  logic                out_valid_o;
  logic                out_ready_i = 1'b1;
  logic [NB*ROW_W-1:0] out_row_o;
  logic [NB*COL_W-1:0] out_col_o;
  logic [NB-1:0]       out_ibank_o;

  always #5 clk_i = ~clk_i;

  tex_bank_mapper #(.MAP_LG(MAP_LG), .LVL_W(LVL_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dut (
    .clk_i, .rst_ni, .clr_i, .req_valid_i, .req_ready_o, .req_lvl_i, .req_u_i,
    .req_v_i, .req_base_row_i, .req_base_col_i, .req_odd_i, .req_repl_i,
    .out_valid_o, .out_ready_i, .out_row_o, .out_col_o, .out_ibank_o
  );

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string tag = "R1";
  int    m_valid = 0;
  int    m_pp = 0;
  int    m_row[NB];
  int    m_col[NB];
  int    m_ib[NB];

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference: trilinear footprint of two levels scattered by parity
  task automatic model_load(input int lvl, input int u, input int v, input int br,
                            input int bc, input int odd, input int repl);
    int d;
    d = (lvl > MAP_LG - 1) ? MAP_LG - 1 : lvl;
    for (int k = 0; k < 2; k++) begin
      int lv, n, lim, pu, pv, pnl;
      lv  = d + k;
      n   = 1 << (MAP_LG - lv);
      lim = (n - 1) / 2;
      pu  = u >> k;
      pv  = v >> k;
      if (pu > n - 1) pu = n - 1;
      if (pv > n - 1) pv = n - 1;
      pnl = (lv % 2) ^ odd;
      for (int rp = 0; rp < 2; rp++) begin
        for (int cp = 0; cp < 2; cp++) begin
          int hr, hc, b;
          hr = (rp == 1) ? pv / 2 : (((pv + 1) / 2 > lim) ? lim : (pv + 1) / 2);
          hc = (cp == 1) ? pu / 2 : (((pu + 1) / 2 > lim) ? lim : (pu + 1) / 2);
          b  = pnl * 4 + rp * 2 + cp;
          m_row[b] = (br + hr) % (1 << ROW_W);
          m_col[b] = (bc + (1 << MAP_LG) - n + hc) % (1 << COL_W);
          m_ib[b]  = (repl != 0) ? (m_pp ^ pnl) : 0;
        end
      end
    end
  endtask

  task automatic compare_outputs();
    check(out_valid_o == 1'(m_valid), "R8 out_valid", int'(out_valid_o), m_valid);
    if (m_valid != 0) begin
      for (int b = 0; b < NB; b++) begin
        check(int'(out_row_o[b*ROW_W +: ROW_W]) == m_row[b],
              $sformatf("R2/R3 row bank %0d", b), int'(out_row_o[b*ROW_W +: ROW_W]), m_row[b]);
        check(int'(out_col_o[b*COL_W +: COL_W]) == m_col[b],
              $sformatf("R2/R3 col bank %0d", b), int'(out_col_o[b*COL_W +: COL_W]), m_col[b]);
        check(int'(out_ibank_o[b]) == m_ib[b],
              $sformatf("R5 ibank bank %0d", b), int'(out_ibank_o[b]), m_ib[b]);
      end
    end
  endtask

  // called at a falling edge; runs one clock
  task automatic cycle(input bit vld, input int lvl, input int u, input int v,
                       input int br, input int bc, input bit odd, input bit repl,
                       input bit rdy, input bit clr);
    bit acc;
    compare_outputs();
    req_valid_i    = vld;
    req_lvl_i      = LVL_W'(lvl);
    req_u_i        = MAP_LG'(u);
    req_v_i        = MAP_LG'(v);
    req_base_row_i = ROW_W'(br);
    req_base_col_i = COL_W'(bc);
    req_odd_i      = odd;
    req_repl_i     = repl;
    out_ready_i    = rdy;
    clr_i          = clr;
    #1;
    // R10
    check(req_ready_o == ((m_valid == 0) || rdy), "R10 req_ready",
          int'(req_ready_o), int'((m_valid == 0) || rdy));
    acc = vld && ((m_valid == 0) || rdy);
    if (acc) begin
      model_load(lvl, u, v, br, bc, int'(odd), int'(repl));
      m_valid = 1;
    end else if (rdy) begin
      m_valid = 0;
    end
    if (clr) m_pp = 0;
    else if (acc && repl) m_pp ^= 1;
    @(negedge clk_i);
  endtask

  task automatic lookup(input int lvl, input int u, input int v, input int br,
                        input int bc, input bit odd, input bit repl);
    cycle(1'b1, lvl, u, v, br, bc, odd, repl, 1'b1, 1'b0);
  endtask

  task automatic idle();
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    tag = "R1";
    check(out_valid_o == 1'b0, "R1 out_valid in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1 out_valid after reset", int'(out_valid_o), 0);
    check(req_ready_o == 1'b1, "R1 req_ready after reset", int'(req_ready_o), 1);

    // R2 R3: interior, both parities, base offsets
    tag = "R2";
    lookup(0, 5, 10, 0, 0, 1'b0, 1'b0);
    lookup(3, 30, 3, 100, 40, 1'b1, 1'b0);
    lookup(5, 2, 7, 513, 700, 1'b0, 1'b0);
    // R3: edge and beyond-edge clamping, wrap of base
    tag = "R3";
    lookup(0, 255, 255, 0, 0, 1'b0, 1'b0);
    lookup(2, 200, 63, 5, 9, 1'b1, 1'b0);
    lookup(1, 127, 128, 1020, 1000, 1'b0, 1'b0);
    // R4: top usable level and out-of-range levels
    tag = "R4";
    lookup(7, 1, 1, 12, 34, 1'b0, 1'b0);
    lookup(12, 3, 0, 12, 34, 1'b1, 1'b0);
    lookup(15, 255, 255, 0, 0, 1'b0, 1'b0);
    idle();
    // R5 R6: ping-pong advances only on accepted replicated lookups
    tag = "R6";
    lookup(0, 8, 8, 0, 0, 1'b0, 1'b1);
    lookup(0, 9, 8, 0, 0, 1'b0, 1'b1);
    lookup(0, 9, 9, 0, 0, 1'b0, 1'b0);
    lookup(1, 9, 9, 0, 0, 1'b1, 1'b1);
    lookup(2, 9, 9, 0, 0, 1'b0, 1'b1);
    // R7: clear alone, then clear with an accepted replicated lookup
    tag = "R7";
    cycle(1'b0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1);
    lookup(0, 1, 1, 0, 0, 1'b0, 1'b1);
    cycle(1'b1, 0, 2, 2, 0, 0, 1'b0, 1'b1, 1'b1, 1'b1);
    lookup(0, 3, 3, 0, 0, 1'b0, 1'b1);
    // R9 R10: stalled output with a different pending request
    tag = "R9";
    lookup(4, 6, 6, 1, 1, 1'b0, 1'b1);
    cycle(1'b1, 6, 1, 2, 3, 4, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 6, 1, 2, 3, 4, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 6, 1, 2, 3, 4, 1'b1, 1'b1, 1'b0, 1'b0);
    cycle(1'b1, 6, 1, 2, 3, 4, 1'b1, 1'b1, 1'b1, 1'b0);
    idle();
    idle();
    // R8 and all: random traffic and backpressure
    tag = "R8";
    for (int i = 0; i < 2000; i++) begin
      int u, v;
      u = ($urandom_range(0, 3) == 0) ? 255 - $urandom_range(0, 2) : $urandom_range(0, 255);
      v = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2) : $urandom_range(0, 255);
      cycle(bit'($urandom_range(0, 9) < 7), $urandom_range(0, 15), u, v,
            $urandom_range(0, 1023), $urandom_range(0, 1023), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 1)), bit'($urandom_range(0, 9) < 7),
            bit'($urandom_range(0, 19) == 0));
    end
    idle();
    idle();
    compare_outputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule